// File: doc/BRIEF.md
# Gated Timer/Counter Channel

This block is one channel of a microcontroller-style timer/counter. It advances a count register either on internal time ticks or on falling edges of an external event pin. The run bit and, when enabled, a level on an external gate pin decide whether counting is allowed. Two mode bits choose the counter shape: 13-bit, 16-bit, 8-bit with auto-reload, or two independent 8-bit halves.

When the count rolls over, the block sets an overflow flag that serves as an interrupt request. Software clears the flag through the register port, and an interrupt-acknowledge pulse also clears it. Both pins are asynchronous and pass through a synchronizer before use. Event edges are sampled on internal ticks, so at most one event is counted per tick.

Register port: address 0 is control, address 1 is the low count byte, address 2 is the high count byte, and address 3 reads as zero. Control bits are: [1:0] mode, [2] event select, [3] gate enable, [4] run, [5] overflow flag, [6] high-half overflow flag, and [7] reads 0.

Top module: `gated_timer`

## Requirements
- R1: After reset, the control, low and high registers read 0x00 and both flags are low.
- R2: While the run bit is 0, the count holds its value regardless of ticks or pin activity.
- R3: With gate enable (bit 3) set, the main count advances only while the synchronized gate pin is high and run is set.
- R4: With gate enable clear, the gate pin level has no effect and run alone enables counting.
- R5: With event select (bit 2) = 1, the count advances once per falling edge of the event pin, sampled on ticks. Rising edges do not advance it, and several edges between two ticks count at most once.
- R6: With event select = 0, the count advances by one on every clock with tick_i high while enabled.
- R7: Mode 1 (bits 1:0 = 01) is a 16-bit count {high,low}. Rolling from 0xFFFF to 0x0000 sets the overflow flag (bit 5, ovf_o).
- R8: Mode 0 is a 13-bit count of high byte and low bits [4:0]. Low bits [7:5] hold, a carry from low bit 4 increments the high byte, and rollover from all ones sets the overflow flag.
- R9: Mode 2 counts the low byte. On its rollover the low byte reloads from the high byte and the overflow flag is set.
- R10: Mode 3 counts the low byte under run and gate control and sets the overflow flag on its rollover. The high byte counts ticks under run only and sets the high-half flag (bit 6, ovf_hi_o) on its rollover.
- R11: A control write with a 0 in a flag bit clears that flag. Writing 1 to a flag bit leaves it unchanged and never sets it.
- R12: A one-cycle ack_i pulse clears the overflow flag.
- R13: A hardware overflow in the same cycle as a software clear or an ack leaves the flag set.
- R14: Writes to addresses 1 and 2 load the low and high count bytes, and those values read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| tick_i | input | 1 | Internal time tick enable |
| cnt_pin_i | input | 1 | External event pin (asynchronous) |
| gate_pin_i | input | 1 | External gate pin (asynchronous) |
| ack_i | input | 1 | Interrupt-acknowledge pulse |
| ovf_o | output | 1 | Overflow flag / interrupt request |
| ovf_hi_o | output | 1 | High-half overflow flag in mode 3 |

## Verification
The hold and gating assertions assume that no register write lands in the cycle they observe, and that the gate-hold check sees a mode other than the split mode, where the high half runs without gating. The stimulus sets tick_i low during every register write that starts or stops counting. It changes the gate and event pins only while ticks are off, or lets them settle for several cycles, so that each expected count follows exactly from the number of tick cycles or falling edges driven. Same-cycle collisions of overflow with clear or acknowledge are created deliberately, one at a time.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_13    = 2'd0,
    MODE_16    = 2'd1,
    MODE_8R    = 2'd2,
    MODE_SPLIT = 2'd3
  } tmr_mode_e;

  localparam int ADDR_W    = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LO   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_HI   = 2'd2;

  localparam int CB_EVT    = 2;
  localparam int CB_GATE   = 3;
  localparam int CB_RUN    = 4;
  localparam int CB_OVF    = 5;
  localparam int NUM_FLAGS = 2;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic sw_clr_i,
  input  logic ack_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 flag_q <= 1'b0;
    else if (set_i)              flag_q <= 1'b1;  // set beats clear
    else if (sw_clr_i || ack_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);  // R13
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !set_i |=> !flag_q);  // R12
  AST_NO_SPONT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_q && !set_i |=> !flag_q);  // R11
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tmr_mode_e         mode_i,
  input  logic              inc_i,
  input  logic              inc_hi_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              ovf_o,
  output logic              ovf_hi_o
);
  localparam int W16 = 2 * BYTE_W;

  logic [BYTE_W-1:0] lo_q, hi_q, lo_d, hi_d;
  logic              ovf, ovf_hi;

  always_comb begin
    lo_d   = lo_q;
    hi_d   = hi_q;
    ovf    = 1'b0;
    ovf_hi = 1'b0;
    unique case (mode_i)
      MODE_13: if (inc_i) begin
        lo_d[PRE_W-1:0] = lo_q[PRE_W-1:0] + PRE_W'(1);
        if (&lo_q[PRE_W-1:0]) begin
          hi_d = hi_q + BYTE_W'(1);
          ovf  = &hi_q;
        end
      end
      MODE_16: if (inc_i) begin
        {hi_d, lo_d} = {hi_q, lo_q} + W16'(1);
        ovf          = &{hi_q, lo_q};
      end
      MODE_8R: if (inc_i) begin
        if (&lo_q) begin
          lo_d = hi_q;
          ovf  = 1'b1;
        end else begin
          lo_d = lo_q + BYTE_W'(1);
        end
      end
      MODE_SPLIT: begin
        if (inc_i) begin
          lo_d = lo_q + BYTE_W'(1);
          ovf  = &lo_q;
        end
        if (inc_hi_i) begin
          hi_d   = hi_q + BYTE_W'(1);
          ovf_hi = &hi_q;
        end
      end
      default: ;
    endcase
    if (wr_lo_i) lo_d = wdata_i;
    if (wr_hi_i) hi_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo_o     = lo_q;
  assign hi_o     = hi_q;
  assign ovf_o    = ovf;
  assign ovf_hi_o = ovf_hi;

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i && !inc_hi_i && !wr_lo_i && !wr_hi_i |=> $stable(lo_q) && $stable(hi_q));  // R2
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_8R && inc_i && (&lo_q) && !wr_lo_i |=> lo_q == $past(hi_q));  // R9
  AST_WRAP16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_16 && inc_i && (&{hi_q, lo_q}) && !wr_lo_i && !wr_hi_i
    |=> lo_q == '0 && hi_q == '0);  // R7
endmodule

// File: rtl/gated_timer.sv
module gated_timer
  import tmr_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int PRE_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              tick_i,
  input  logic              cnt_pin_i,
  input  logic              gate_pin_i,
  input  logic              ack_i,
  output logic              ovf_o,
  output logic              ovf_hi_o
);
  tmr_mode_e mode_q;
  logic      evt_q, gate_q, run_q;
  logic      cnt_prev_q;
  logic [1:0] pins_s;
  logic      cnt_s, gate_s, fall, src, allow;
  logic      inc_main, inc_hi;
  logic      wr_ctrl, wr_lo, wr_hi;
  logic [BYTE_W-1:0] lo, hi;
  logic [NUM_FLAGS-1:0] set_v, ack_v, clr_v, flag_v;

  tmr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({gate_pin_i, cnt_pin_i}),
    .sync_o  (pins_s)
  );
  assign cnt_s  = pins_s[0];
  assign gate_s = pins_s[1];

  // edge history advances only on ticks: one event per tick at most
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_prev_q <= 1'b0;
    else if (tick_i) cnt_prev_q <= cnt_s;
  end
  assign fall = cnt_prev_q & ~cnt_s;

  assign wr_ctrl = wr_en_i && (addr_i == ADDR_CTRL);
  assign wr_lo   = wr_en_i && (addr_i == ADDR_LO);
  assign wr_hi   = wr_en_i && (addr_i == ADDR_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_13;
      evt_q  <= 1'b0;
      gate_q <= 1'b0;
      run_q  <= 1'b0;
    end else if (wr_ctrl) begin
      mode_q <= tmr_mode_e'(wdata_i[1:0]);
      evt_q  <= wdata_i[CB_EVT];
      gate_q <= wdata_i[CB_GATE];
      run_q  <= wdata_i[CB_RUN];
    end
  end

  assign src      = evt_q ? (tick_i & fall) : tick_i;
  assign allow    = run_q & (~gate_q | gate_s);
  assign inc_main = allow & src;
  assign inc_hi   = run_q & tick_i & (mode_q == MODE_SPLIT);

  tmr_count #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) u_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode_q),
    .inc_i    (inc_main),
    .inc_hi_i (inc_hi),
    .wr_lo_i  (wr_lo),
    .wr_hi_i  (wr_hi),
    .wdata_i  (wdata_i),
    .lo_o     (lo),
    .hi_o     (hi),
    .ovf_o    (set_v[0]),
    .ovf_hi_o (set_v[1])
  );

  assign ack_v = {1'b0, ack_i};

  for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
    assign clr_v[k] = wr_ctrl & ~wdata_i[CB_OVF+k];
    tmr_flag u_flag (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (set_v[k]),
      .sw_clr_i (clr_v[k]),
      .ack_i    (ack_v[k]),
      .flag_o   (flag_v[k])
    );
  end

  assign ovf_o    = flag_v[0];
  assign ovf_hi_o = flag_v[1];

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: begin
        rdata_o[1:0]          = mode_q;
        rdata_o[CB_EVT]       = evt_q;
        rdata_o[CB_GATE]      = gate_q;
        rdata_o[CB_RUN]       = run_q;
        rdata_o[CB_OVF]       = flag_v[0];
        rdata_o[CB_OVF+1]     = flag_v[1];
      end
      ADDR_LO: rdata_o = lo;
      ADDR_HI: rdata_o = hi;
      default: rdata_o = '0;
    endcase
  end

  AST_RUN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q && !wr_en_i |=> $stable(lo) && $stable(hi));  // R2
  AST_GATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_q && !gate_s && !wr_en_i && mode_q != MODE_SPLIT |=> $stable(lo) && $stable(hi));  // R3
  AST_FLAG_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(set_v[0]));  // R7
endmodule

// File: tb/sim_gated_timer.sv
module sim_gated_timer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       tick_i = 1'b0;
  logic       cnt_pin_i = 1'b0;
  logic       gate_pin_i = 1'b0;
  logic       ack_i = 1'b0;
  logic       ovf_o, ovf_hi_o;

  int   n_vec = 0;
  int   n_bad = 0;
  logic rd_pend = 1'b0;
  logic done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk_i = ~clk_i;  // 50 MHz

  gated_timer u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .tick_i(tick_i),
    .cnt_pin_i(cnt_pin_i), .gate_pin_i(gate_pin_i), .ack_i(ack_i),
    .ovf_o(ovf_o), .ovf_hi_o(ovf_hi_o)
  );

  // monitor: pops expected items as the read data appears
  always @(negedge clk_i) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_vec++;
      if (rdata_o !== e) begin
        n_bad++;
        $display("FAIL %s addr=%0d actual=%02h expected=%02h", t, addr_i, rdata_o, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk_i); #1;
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
    @(posedge clk_i); #1;
    addr_i = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_pend = 1'b1;
    @(posedge clk_i); #1;
    rd_pend = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_i = 1'b1;
    repeat (n) @(posedge clk_i);
    #1 tick_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] pat;
    idle(3);
    rst_ni = 1'b1;
    idle(2);
    // R1 reset state
    rd(2'd0, 8'h00, "R1 ctrl");
    rd(2'd1, 8'h00, "R1 lo");
    rd(2'd2, 8'h00, "R1 hi");
    // R14 direct load
    wr(2'd1, 8'h5A); wr(2'd2, 8'hC3);
    rd(2'd1, 8'h5A, "R14 lo");
    rd(2'd2, 8'hC3, "R14 hi");
    // R2 stopped: ticks ignored
    wr(2'd0, 8'h61); ticks(10);
    rd(2'd1, 8'h5A, "R2 lo");
    rd(2'd2, 8'hC3, "R2 hi");
    // R6 tick counting, irregular pattern with six ones
    wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd0, 8'h71);
    pat = 8'b1110_1101;
    for (int i = 0; i < 8; i++) begin
      tick_i = pat[i];
      @(posedge clk_i); #1;
    end
    tick_i = 1'b0;
    wr(2'd0, 8'h61);
    rd(2'd1, 8'h06, "R6 lo");
    rd(2'd2, 8'h00, "R6 hi");
    // R4 gating disabled, gate pin low
    gate_pin_i = 1'b0;
    wr(2'd0, 8'h71); ticks(6); wr(2'd0, 8'h61);
    rd(2'd1, 8'h0C, "R4 lo");
    // R3 gating enabled
    wr(2'd0, 8'h79); ticks(10);
    gate_pin_i = 1'b1; idle(4); ticks(7);
    gate_pin_i = 1'b0;
    wr(2'd0, 8'h69);
    rd(2'd1, 8'h13, "R3 lo");
    rd(2'd0, 8'h09, "R3 ctrl");
    // R5 event counting
    wr(2'd1, 8'h00); wr(2'd0, 8'h75);
    tick_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      cnt_pin_i = 1'b1; idle(4);
      cnt_pin_i = 1'b0; idle(4);
    end
    cnt_pin_i = 1'b1; idle(4);
    tick_i = 1'b0;
    cnt_pin_i = 1'b0; idle(4);
    cnt_pin_i = 1'b1; idle(4);
    cnt_pin_i = 1'b0; idle(4);
    tick_i = 1'b1; idle(4);
    tick_i = 1'b0;
    wr(2'd0, 8'h65);
    rd(2'd1, 8'h04, "R5 lo");
    // R7 16-bit rollover
    wr(2'd1, 8'hFE); wr(2'd2, 8'hFF); wr(2'd0, 8'h71); ticks(3); wr(2'd0, 8'h61);
    rd(2'd1, 8'h01, "R7 lo");
    rd(2'd2, 8'h00, "R7 hi");
    rd(2'd0, 8'h21, "R7 flag");
    // R11 software clear, no software set
    wr(2'd0, 8'h01);
    rd(2'd0, 8'h01, "R11 clear");
    wr(2'd0, 8'h61);
    rd(2'd0, 8'h01, "R11 no set");
    // R12 acknowledge clears
    wr(2'd1, 8'hFF); wr(2'd2, 8'hFF); wr(2'd0, 8'h71); ticks(1); wr(2'd0, 8'h61);
    rd(2'd0, 8'h21, "R12 set");
    ack_i = 1'b1; @(posedge clk_i); #1 ack_i = 1'b0;
    rd(2'd0, 8'h01, "R12 ack");
    // R13 set beats software clear
    wr(2'd1, 8'hFF); wr(2'd2, 8'hFF); wr(2'd0, 8'h71);
    @(posedge clk_i); #1;
    tick_i = 1'b1; wr_en_i = 1'b1; addr_i = 2'd0; wdata_i = 8'h11;
    @(posedge clk_i); #1;
    tick_i = 1'b0; wr_en_i = 1'b0;
    wr(2'd0, 8'h61);
    rd(2'd0, 8'h21, "R13 sw");
    // R13 set beats acknowledge
    wr(2'd1, 8'hFF); wr(2'd2, 8'hFF); wr(2'd0, 8'h71);
    tick_i = 1'b1; ack_i = 1'b1;
    @(posedge clk_i); #1;
    tick_i = 1'b0; ack_i = 1'b0;
    wr(2'd0, 8'h61);
    rd(2'd0, 8'h21, "R13 ack");
    // R8 13-bit mode
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hFE); wr(2'd2, 8'h12); wr(2'd0, 8'h10); ticks(2); wr(2'd0, 8'h60);
    rd(2'd1, 8'hE0, "R8 lo carry");
    rd(2'd2, 8'h13, "R8 hi carry");
    rd(2'd0, 8'h00, "R8 no flag");
    wr(2'd1, 8'hBF); wr(2'd2, 8'hFF); wr(2'd0, 8'h10); ticks(1); wr(2'd0, 8'h60);
    rd(2'd1, 8'hA0, "R8 lo wrap");
    rd(2'd2, 8'h00, "R8 hi wrap");
    rd(2'd0, 8'h20, "R8 flag");
    // R9 auto-reload
    wr(2'd0, 8'h02);
    wr(2'd1, 8'hFE); wr(2'd2, 8'hF0); wr(2'd0, 8'h12); ticks(3); wr(2'd0, 8'h62);
    rd(2'd1, 8'hF1, "R9 lo");
    rd(2'd2, 8'hF0, "R9 hi");
    rd(2'd0, 8'h22, "R9 flag");
    // R10 split mode, low half gated off
    wr(2'd0, 8'h0B); gate_pin_i = 1'b0;
    wr(2'd1, 8'hFF); wr(2'd2, 8'hFE); wr(2'd0, 8'h1B); ticks(3); wr(2'd0, 8'h6B);
    rd(2'd1, 8'hFF, "R10 lo gated");
    rd(2'd2, 8'h01, "R10 hi");
    rd(2'd0, 8'h4B, "R10 hi flag");
    wr(2'd0, 8'h2B);
    rd(2'd0, 8'h0B, "R11 hi clear");
    idle(3);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", exp_q.size());
    end
    finish_run();
  end
endmodule